// File: doc/BRIEF.md
# Dual-Channel Odd-Parity Bus Transceiver

This block joins a narrow data bus (side A, eight bits per channel) to a wider bus (side B) that carries the same eight data bits plus one parity line. Data crosses in either direction without inversion. When a channel sends from A to B, it computes a parity bit over the eight A bits and drives it on the parity line. The nine B bits then hold an odd number of ones. When a channel sends from B to A, the parity line becomes an input. The nine received bits are checked, and a clocked active-low error flag records the result.

Tri-state pins are modelled as a separate input, output and drive-enable for each side. Each side has its own active-low output-enable request. A channel never drives both sides at once: if both requests are active together, it drives neither side. Two channels sit side by side, and each has its own clock, clear, enables and error flag. The data width, the channel count and the parity sense are parameters, and their defaults are eight bits, two channels and odd parity.

Top module: `dual_parity_xcvr`

## Requirements
- R1: With `b_oe_n_i` low and `a_oe_n_i` high, the channel asserts `b_drv_o`, deasserts `a_drv_o`, and `b_data_o` equals `a_data_i` bit for bit.
- R2: While `b_drv_o` is asserted, `par_o` equals the inverted XOR of the eight A data bits, so the nine bits {`par_o`, `b_data_o`} hold an odd number of ones.
- R3: With `a_oe_n_i` low and `b_oe_n_i` high, the channel asserts `a_drv_o`, deasserts `b_drv_o` (the parity line is then an input), and `a_data_o` equals `b_data_i`.
- R4: If both enable requests are low, or both are high, neither `a_drv_o` nor `b_drv_o` is asserted.
- R5: On a rising clock edge with `clr_n_i` high and the channel in B-to-A mode (R3), `err_n_o` takes 1 when {`par_i`, `b_data_i`} has an odd number of ones and 0 otherwise.
- R6: On a rising clock edge with `clr_n_i` high and the channel not in B-to-A mode, `err_n_o` keeps its value.
- R7: On a rising clock edge with `clr_n_i` low, `err_n_o` becomes 1 whatever the other inputs are. This is also its reset state.
- R8: The two channels are independent: the inputs of one channel change no output of the other.
- R9: `err_n_o` changes only at a clock edge. A bad word that is applied between edges leaves the flag unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 2 | Clock for each channel |
| clr_n_i | input | 2 | Active-low synchronous clear of each error flag |
| a_oe_n_i | input | 2 | Active-low request to drive side A (B-to-A transfer) |
| b_oe_n_i | input | 2 | Active-low request to drive side B and parity (A-to-B transfer) |
| a_data_i | input | 16 | Side A received data, channel 0 in bits 7:0 |
| a_data_o | output | 16 | Side A driven data |
| a_drv_o | output | 2 | Side A drive enable for each channel |
| b_data_i | input | 16 | Side B received data |
| b_data_o | output | 16 | Side B driven data |
| b_drv_o | output | 2 | Side B and parity drive enable for each channel |
| par_i | input | 2 | Parity line as received |
| par_o | output | 2 | Generated parity for each channel |
| err_n_o | output | 2 | Registered active-low parity-error flag |

## Verification
In A-to-B mode the bench sweeps all 256 A-side values on channel 0 and feeds channel 1 the complement at the same time. This separates a wrong parity sense and a stuck data bit from leakage between channels. In B-to-A mode all 512 combinations of data and parity are applied, and the flag is compared one edge later with the parity count worked out in the bench. This sweep covers every single-bit and multi-bit error. Directed sequences flip each data bit and the parity bit of a clean word in turn, and they confirm three things: the flag falls on exactly the following edge, it stays unchanged before that edge, and it returns high after a clean word. Further sequences hold the flag in the idle, A-to-B and clash modes, and check that a clear overrides a bad word.

// File: rtl/parbus_pkg.sv
package parbus_pkg;

   // bit 1: side A drive requested, bit 0: side B drive requested
   typedef enum logic [1:0] {
      XF_IDLE  = 2'b00,
      XF_A2B   = 2'b01,
      XF_B2A   = 2'b10,
      XF_CLASH = 2'b11
   } xfer_e;

   function automatic xfer_e decode_xfer(input logic a_oe_n, input logic b_oe_n);
      return xfer_e'({~a_oe_n, ~b_oe_n});
   endfunction

endpackage

// File: rtl/pb_parity_tree.sv
module pb_parity_tree #(
   parameter int W   = 8,
   parameter bit ODD = 1'b1
) (
   input  logic [W-1:0] data_i,
   input  logic         par_i,
   output logic         gen_o,
   output logic         ok_o
);
   logic sum;

   assign sum = ^data_i;

   generate
      if (ODD) begin : g_odd
         assign gen_o = ~sum;
         assign ok_o  = sum ^ par_i;
      end else begin : g_even
         assign gen_o = sum;
         assign ok_o  = ~(sum ^ par_i);
      end
   endgenerate

endmodule

// File: rtl/pb_err_reg.sv
module pb_err_reg (
   input  logic clk_i,
   input  logic clr_n_i,
   input  logic upd_i,
   input  logic ok_i,
   output logic err_n_o
);
   always_ff @(posedge clk_i) begin
      if (!clr_n_i)
         err_n_o <= 1'b1;
      else if (upd_i)
         err_n_o <= ok_i;
   end
endmodule

// File: rtl/pb_channel.sv
module pb_channel
   import parbus_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter bit ODD    = 1'b1
) (
   input  logic              clk_i,
   input  logic              clr_n_i,
   input  logic              a_oe_n_i,
   input  logic              b_oe_n_i,
   input  logic [DATA_W-1:0] a_data_i,
   output logic [DATA_W-1:0] a_data_o,
   output logic              a_drv_o,
   input  logic [DATA_W-1:0] b_data_i,
   output logic [DATA_W-1:0] b_data_o,
   output logic              b_drv_o,
   input  logic              par_i,
   output logic              par_o,
   output logic              err_n_o
);
   xfer_e mode;
   logic  rx_ok;
   logic  tx_par;
   logic  rx_unused;

   assign mode = decode_xfer(a_oe_n_i, b_oe_n_i);

   assign a_drv_o  = (mode == XF_B2A);
   assign b_drv_o  = (mode == XF_A2B);
   assign a_data_o = b_data_i;
   assign b_data_o = a_data_i;
   assign par_o    = tx_par;

   pb_parity_tree #(.W(DATA_W), .ODD(ODD)) u_tx_tree (
      .data_i (a_data_i),
      .par_i  (1'b0),
      .gen_o  (tx_par),
      .ok_o   (rx_unused)
   );

   logic tx_unused;
   pb_parity_tree #(.W(DATA_W), .ODD(ODD)) u_rx_tree (
      .data_i (b_data_i),
      .par_i  (par_i),
      .gen_o  (tx_unused),
      .ok_o   (rx_ok)
   );

   pb_err_reg u_err (
      .clk_i   (clk_i),
      .clr_n_i (clr_n_i),
      .upd_i   (mode == XF_B2A),
      .ok_i    (rx_ok),
      .err_n_o (err_n_o)
   );

endmodule

// File: rtl/dual_parity_xcvr.sv
module dual_parity_xcvr #(
   parameter int DATA_W = 8,
   parameter int NUM_CH = 2,
   parameter bit ODD    = 1'b1,
   localparam int BUS_W = DATA_W * NUM_CH
) (
   input  logic [NUM_CH-1:0] clk_i,
   input  logic [NUM_CH-1:0] clr_n_i,
   input  logic [NUM_CH-1:0] a_oe_n_i,
   input  logic [NUM_CH-1:0] b_oe_n_i,
   input  logic [BUS_W-1:0]  a_data_i,
   output logic [BUS_W-1:0]  a_data_o,
   output logic [NUM_CH-1:0] a_drv_o,
   input  logic [BUS_W-1:0]  b_data_i,
   output logic [BUS_W-1:0]  b_data_o,
   output logic [NUM_CH-1:0] b_drv_o,
   input  logic [NUM_CH-1:0] par_i,
   output logic [NUM_CH-1:0] par_o,
   output logic [NUM_CH-1:0] err_n_o
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("dual_parity_xcvr: DATA_W must be at least 1");
      end
      if (NUM_CH < 1) begin : g_bad_count
         $error("dual_parity_xcvr: NUM_CH must be at least 1");
      end

      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         pb_channel #(.DATA_W(DATA_W), .ODD(ODD)) u_ch (
            .clk_i    (clk_i[c]),
            .clr_n_i  (clr_n_i[c]),
            .a_oe_n_i (a_oe_n_i[c]),
            .b_oe_n_i (b_oe_n_i[c]),
            .a_data_i (a_data_i[c*DATA_W +: DATA_W]),
            .a_data_o (a_data_o[c*DATA_W +: DATA_W]),
            .a_drv_o  (a_drv_o[c]),
            .b_data_i (b_data_i[c*DATA_W +: DATA_W]),
            .b_data_o (b_data_o[c*DATA_W +: DATA_W]),
            .b_drv_o  (b_drv_o[c]),
            .par_i    (par_i[c]),
            .par_o    (par_o[c]),
            .err_n_o  (err_n_o[c])
         );
      end
   endgenerate

endmodule

// File: rtl/pb_xcvr_chk.sv
module pb_xcvr_chk #(
   parameter int DATA_W = 8,
   parameter int NUM_CH = 2,
   parameter bit ODD    = 1'b1,
   localparam int BUS_W = DATA_W * NUM_CH
) (
   input logic [NUM_CH-1:0] clk_i,
   input logic [NUM_CH-1:0] clr_n_i,
   input logic [NUM_CH-1:0] a_oe_n_i,
   input logic [NUM_CH-1:0] b_oe_n_i,
   input logic [BUS_W-1:0]  a_data_i,
   input logic [BUS_W-1:0]  a_data_o,
   input logic [NUM_CH-1:0] a_drv_o,
   input logic [BUS_W-1:0]  b_data_i,
   input logic [BUS_W-1:0]  b_data_o,
   input logic [NUM_CH-1:0] b_drv_o,
   input logic [NUM_CH-1:0] par_i,
   input logic [NUM_CH-1:0] par_o,
   input logic [NUM_CH-1:0] err_n_o
);
   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
         logic armed = 1'b0;
         logic b2a;
         logic rx_odd;

         always_ff @(posedge clk_i[g]) begin
            if (!clr_n_i[g]) armed <= 1'b1;
         end

         assign b2a    = !a_oe_n_i[g] && b_oe_n_i[g];
         assign rx_odd = ^{par_i[g], b_data_i[g*DATA_W +: DATA_W]};

         // R1
         a2b_pass_chk: assert property (@(posedge clk_i[g]) disable iff (!armed)
            b_drv_o[g] |-> (b_data_o[g*DATA_W +: DATA_W] == a_data_i[g*DATA_W +: DATA_W]));

         // R2
         gen_par_chk: assert property (@(posedge clk_i[g]) disable iff (!armed)
            b_drv_o[g] |-> ((^{par_o[g], b_data_o[g*DATA_W +: DATA_W]}) == ODD));

         // R3
         b2a_pass_chk: assert property (@(posedge clk_i[g]) disable iff (!armed)
            a_drv_o[g] |-> (a_data_o[g*DATA_W +: DATA_W] == b_data_i[g*DATA_W +: DATA_W]));

         // R4
         no_contention_chk: assert property (@(posedge clk_i[g]) disable iff (!armed)
            !(a_drv_o[g] && b_drv_o[g]));

         // R5
         err_capture_chk: assert property (@(posedge clk_i[g]) disable iff (!armed)
            (clr_n_i[g] && b2a) |=> (err_n_o[g] == (ODD ? $past(rx_odd) : !$past(rx_odd))));

         // R6
         err_hold_chk: assert property (@(posedge clk_i[g]) disable iff (!armed)
            (clr_n_i[g] && !b2a) |=> $stable(err_n_o[g]));

         // R7
         clear_high_chk: assert property (@(posedge clk_i[g]) disable iff (!armed)
            !clr_n_i[g] |=> err_n_o[g]);
      end
   endgenerate
endmodule

bind dual_parity_xcvr pb_xcvr_chk #(
   .DATA_W (DATA_W),
   .NUM_CH (NUM_CH),
   .ODD    (ODD)
) u_chk (
   .clk_i    (clk_i),
   .clr_n_i  (clr_n_i),
   .a_oe_n_i (a_oe_n_i),
   .b_oe_n_i (b_oe_n_i),
   .a_data_i (a_data_i),
   .a_data_o (a_data_o),
   .a_drv_o  (a_drv_o),
   .b_data_i (b_data_i),
   .b_data_o (b_data_o),
   .b_drv_o  (b_drv_o),
   .par_i    (par_i),
   .par_o    (par_o),
   .err_n_o  (err_n_o)
);

// File: tb/dual_parity_xcvr_bench.sv
`timescale 1ns/1ps
module dual_parity_xcvr_bench;
   localparam int DW = 8;
   localparam int NC = 2;

   logic        clk = 1'b0;
   logic [1:0]  clk_v;
   logic [1:0]  clr_n, a_oe_n, b_oe_n, par_in;
   logic [15:0] a_in, b_in;
   logic [15:0] a_out, b_out;
   logic [1:0]  a_drv, b_drv, par_out, err_n;

   int n_cmp  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;
   assign clk_v = {clk, clk};

   dual_parity_xcvr #(.DATA_W(DW), .NUM_CH(NC), .ODD(1'b1)) u_dual_parity_xcvr (
      .clk_i    (clk_v),
      .clr_n_i  (clr_n),
      .a_oe_n_i (a_oe_n),
      .b_oe_n_i (b_oe_n),
      .a_data_i (a_in),
      .a_data_o (a_out),
      .a_drv_o  (a_drv),
      .b_data_i (b_in),
      .b_data_o (b_out),
      .b_drv_o  (b_drv),
      .par_i    (par_in),
      .par_o    (par_out),
      .err_n_o  (err_n)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic odd9(input logic [8:0] w);
      return ^w;
   endfunction

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
   endtask

   initial begin
      #500000;
      if (!done) begin
         n_cmp++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [8:0] prev;
      logic [8:0] clean;
      clr_n  = 2'b00;
      a_oe_n = 2'b11;
      b_oe_n = 2'b11;
      a_in   = '0;
      b_in   = '0;
      par_in = '0;
      repeat (2) @(negedge clk);
      // R7 reset state, R4 idle drives nothing
      check("R7 reset flag", err_n, 2'b11);
      check("R4 idle a_drv", a_drv, 2'b00);
      check("R4 idle b_drv", b_drv, 2'b00);
      clr_n = 2'b11;

      // R1 R2 R8: exhaustive A-to-B on ch0, complement on ch1
      a_oe_n = 2'b11;
      b_oe_n = 2'b00;
      for (int v = 0; v < 256; v++) begin
         @(negedge clk);
         a_in = {~v[7:0], v[7:0]};
         #1;
         check("R1 b_data", b_out, {~v[7:0], v[7:0]});
         check("R1 drv", {a_drv, b_drv}, 4'b0011);
         check("R2 parity ch0", par_out[0], ~^v[7:0]);
         check("R8 parity ch1", par_out[1], ~^(~v[7:0]));
      end
      @(negedge clk);
      check("R6 hold in A2B", err_n, 2'b11);

      // R3 R5: exhaustive B-to-A on ch0, ch1 stays A-to-B
      a_oe_n = 2'b10;
      b_oe_n = 2'b01;
      for (int w = 0; w < 512; w++) begin
         @(negedge clk);
         if (w > 0) check("R5 flag", err_n[0], odd9(prev));
         prev      = w[8:0];
         b_in[7:0] = w[7:0];
         par_in[0] = w[8];
         #1;
         check("R3 a_data", a_out[7:0], w[7:0]);
         check("R3 drv", {a_drv[0], b_drv[0]}, 2'b10);
      end
      @(negedge clk);
      check("R5 flag last", err_n[0], odd9(prev));
      check("R8 ch1 untouched", err_n[1], 1'b1);

      // R5 R9: single-bit injection on a clean word
      clean = {~^8'hA5, 8'hA5};
      for (int k = 0; k < 9; k++) begin
         logic [8:0] bad;
         bad = clean ^ (9'd1 << k);
         {par_in[0], b_in[7:0]} = clean;
         @(negedge clk);
         check("R5 clean high", err_n[0], 1'b1);
         {par_in[0], b_in[7:0]} = bad;
         #1;
         check("R9 no change before edge", err_n[0], 1'b1);
         @(negedge clk);
         check("R5 injected low", err_n[0], 1'b0);
         {par_in[0], b_in[7:0]} = clean;
         @(negedge clk);
         check("R5 recovers high", err_n[0], 1'b1);
      end

      // R6: flag low, then idle, A2B and clash modes hold it
      {par_in[0], b_in[7:0]} = clean ^ 9'h100;
      @(negedge clk);
      check("R5 set low", err_n[0], 1'b0);
      {par_in[0], b_in[7:0]} = clean;
      a_oe_n[0] = 1'b1; b_oe_n[0] = 1'b1;
      repeat (2) @(negedge clk);
      check("R6 hold idle", err_n[0], 1'b0);
      a_oe_n[0] = 1'b1; b_oe_n[0] = 1'b0;
      repeat (2) @(negedge clk);
      check("R6 hold A2B", err_n[0], 1'b0);
      a_oe_n[0] = 1'b0; b_oe_n[0] = 1'b0;
      #1;
      check("R4 clash no drive", {a_drv[0], b_drv[0]}, 2'b00);
      repeat (2) @(negedge clk);
      check("R6 hold clash", err_n[0], 1'b0);

      // R7: clear overrides a bad word in B2A mode
      a_oe_n[0] = 1'b0; b_oe_n[0] = 1'b1;
      {par_in[0], b_in[7:0]} = clean ^ 9'h001;
      clr_n[0] = 1'b0;
      @(negedge clk);
      check("R7 clear wins", err_n[0], 1'b1);
      clr_n[0] = 1'b1;
      @(negedge clk);
      check("R5 after clear", err_n[0], 1'b0);

      // R8: ch1 error while ch0 idle with a low flag
      a_oe_n = 2'b01; b_oe_n = 2'b11;
      {par_in[1], b_in[15:8]} = 9'h000;
      @(negedge clk);
      check("R8 ch1 low", err_n[1], 1'b0);
      check("R8 ch0 held", err_n[0], 1'b0);
      check("R8 ch1 a_data", a_out[15:8], 8'h00);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule